// File: doc/BRIEF.md
# Synchronization Status Frame Generator

This block builds and streams the slow-protocol frames that a synchronous Ethernet port uses to advertise the quality level of the clock it forwards. It watches a 4-bit quality code, a 48-bit station address, a one-second tick and an enable. From these it produces complete 64-octet frames, FCS included, on a byte-wide ready/valid stream toward a MAC.

Two kinds of frame are sent. A periodic information frame goes out on every tick. An event frame goes out as soon as the quality code moves. Both kinds carry the same quality TLV and differ only in one flag bit. A holdoff counter spaces frame starts so that the slow-protocol rate ceiling of ten per second is never exceeded. A request that cannot be served at once stays pending until the running frame ends and the holdoff has run out.

Top module: `ssm_frame_gen`

## Requirements
- R1: After reset `m_tvalid` is low and stays low until a frame is requested.
- R2: Every frame is exactly 64 beats, and `m_tlast` is high on the 64th beat only.
- R3: Beats 0–19 are sent in this order:
  - beats 0–5: 01 80 C2 00 00 02;
  - beats 6–11: `src_mac`, most significant octet first;
  - beats 12–19: 88 09 0A 00 19 A7 00 01.
- R4: Beat 20 holds the version 1 in bits 7:4, the event flag in bit 3 and zero in bits 2:0. Beats 21–23 are zero.
- R5: Beats 24–27 are 01, 00, 04 and then {4'h0, quality}. Beats 28–59 are zero padding.
- R6: Beats 60–63 carry the FCS, least significant octet first. The FCS is the complemented reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over beats 0–59.
- R7: A one-cycle `tick_1s` while `en` is high queues an information frame, which has event flag 0.
- R8: A change of `ql` while `en` is high queues an event frame, which has event flag 1. When the block is idle and the holdoff has run out, the first beat is valid no more than 3 cycles after the change.
- R9: The first beats of two frames are at least `HOLDOFF_CYCLES` cycles apart. A request made during a frame or during the holdoff waits and is not lost.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tlast` hold their values.
- R11: While `en` is low, ticks and quality changes are ignored and no frame starts. Raising `en` does not by itself produce a frame.
- R12: When an event and an information request are both pending, the event frame is sent first. The quality code and address in a frame are those present when the frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables message generation |
| tick_1s | input | 1 | One-cycle pulse once per second |
| ql | input | 4 | Current clock quality code |
| src_mac | input | 48 | Station address placed in the frame |
| m_tready | input | 1 | Sink accepts the current beat |
| m_tvalid | output | 1 | Beat is valid |
| m_tdata | output | 8 | Frame octet |
| m_tlast | output | 1 | Final beat of the frame |

## Verification
The assertions assume that `tick_1s` is a single-cycle pulse. They also assume that `src_mac` changes only between frames, so that a frame's address field is stable. The sink may drop `m_tready` at any beat. The stimulus therefore gives only one-cycle ticks and changes the address only while the stream is idle. It applies a pseudo-random `m_tready` pattern in one phase so that stalls fall on many different beats.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   localparam int FRAME_LEN = 64;
   localparam int FCS_LEN   = 4;
   localparam int FCS_POS   = FRAME_LEN - FCS_LEN;
   localparam int IDX_W     = $clog2(FRAME_LEN);

   localparam logic [31:0] CRC_POLY = 32'hEDB88320;
   localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

   typedef struct packed {
      logic        evt;
      logic [3:0]  ql;
      logic [47:0] mac;
   } frame_req_t;

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/ssm_sched.sv
module ssm_sched #(
   parameter int HOLDOFF_CYCLES = 12_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick_1s,
   input  logic [3:0] ql,
   input  logic       busy,
   output logic       start,
   output logic       start_evt
);
   localparam int HW = $clog2(HOLDOFF_CYCLES + 1);

   logic [3:0]    ql_q;
   logic          en_q;
   logic          ev_pend;
   logic          info_pend;
   logic [HW-1:0] hold;
   logic          chg;

   assign chg       = en && en_q && (ql != ql_q);
   assign start     = en && !busy && (hold == '0) && (ev_pend || info_pend);
   assign start_evt = ev_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ql_q      <= '0;
         en_q      <= 1'b0;
         ev_pend   <= 1'b0;
         info_pend <= 1'b0;
         hold      <= '0;
      end else begin
         ql_q <= ql;
         en_q <= en;
         if (!en) begin
            ev_pend   <= 1'b0;
            info_pend <= 1'b0;
         end else begin
            ev_pend   <= (ev_pend && !(start && start_evt)) || chg;
            info_pend <= (info_pend && !(start && !start_evt)) || tick_1s;
         end
         if (start)             hold <= HW'(HOLDOFF_CYCLES);
         else if (hold != '0)   hold <= hold - 1'b1;
      end
   end
endmodule

// File: rtl/ssm_octet_mux.sv
module ssm_octet_mux import ssm_pkg::*; #(
   parameter logic [3:0]  VERSION = 4'h1,
   parameter logic [15:0] ORG_SUB = 16'h0001
) (
   input  logic [IDX_W-1:0] idx,
   input  frame_req_t       req,
   output logic [7:0]       octet
);
   always_comb begin
      case (idx)
         6'd0:  octet = 8'h01;
         6'd1:  octet = 8'h80;
         6'd2:  octet = 8'hC2;
         6'd3:  octet = 8'h00;
         6'd4:  octet = 8'h00;
         6'd5:  octet = 8'h02;
         6'd6:  octet = req.mac[47:40];
         6'd7:  octet = req.mac[39:32];
         6'd8:  octet = req.mac[31:24];
         6'd9:  octet = req.mac[23:16];
         6'd10: octet = req.mac[15:8];
         6'd11: octet = req.mac[7:0];
         6'd12: octet = 8'h88;
         6'd13: octet = 8'h09;
         6'd14: octet = 8'h0A;
         6'd15: octet = 8'h00;
         6'd16: octet = 8'h19;
         6'd17: octet = 8'hA7;
         6'd18: octet = ORG_SUB[15:8];
         6'd19: octet = ORG_SUB[7:0];
         6'd20: octet = {VERSION, req.evt, 3'b000};
         6'd24: octet = 8'h01;
         6'd25: octet = 8'h00;
         6'd26: octet = 8'h04;
         6'd27: octet = {4'h0, req.ql};
         default: octet = 8'h00;
      endcase
   end
endmodule

// File: rtl/ssm_framer.sv
module ssm_framer import ssm_pkg::*; #(
   parameter logic [3:0]  VERSION = 4'h1,
   parameter logic [15:0] ORG_SUB = 16'h0001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  frame_req_t new_req,
   output logic       busy,
   input  logic       m_tready,
   output logic       m_tvalid,
   output logic [7:0] m_tdata,
   output logic       m_tlast
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] FCS_IDX  = IDX_W'(FCS_POS);

   logic [IDX_W-1:0] idx;
   frame_req_t       req;
   logic [31:0]      crc;
   logic [31:0]      fcs;
   logic [7:0]       body;
   logic [7:0]       fcs_b [FCS_LEN];
   logic             beat;

   ssm_octet_mux #(.VERSION(VERSION), .ORG_SUB(ORG_SUB)) u_mux (
      .idx   (idx),
      .req   (req),
      .octet (body)
   );

   assign fcs = ~crc;
   for (genvar k = 0; k < FCS_LEN; k++) begin : g_fcs
      assign fcs_b[k] = fcs[8*k +: 8];
   end

   assign beat     = busy && m_tready;
   assign m_tvalid = busy;
   assign m_tlast  = busy && (idx == LAST_IDX);
   assign m_tdata  = (idx >= FCS_IDX) ? fcs_b[idx[1:0]] : body;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         req  <= '0;
         crc  <= CRC_INIT;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            req  <= new_req;
            crc  <= CRC_INIT;
         end
      end else if (beat) begin
         if (idx < FCS_IDX) crc <= crc32_step(crc, body);
         if (idx == LAST_IDX) busy <= 1'b0;
         else                 idx  <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/ssm_frame_gen.sv
module ssm_frame_gen import ssm_pkg::*; #(
   parameter int          HOLDOFF_CYCLES = 12_500_000,
   parameter logic [3:0]  VERSION        = 4'h1,
   parameter logic [15:0] ORG_SUB        = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        tick_1s,
   input  logic [3:0]  ql,
   input  logic [47:0] src_mac,
   input  logic        m_tready,
   output logic        m_tvalid,
   output logic [7:0]  m_tdata,
   output logic        m_tlast
);
   if (HOLDOFF_CYCLES < 2) begin : g_bad_holdoff
      $error("HOLDOFF_CYCLES must be at least 2");
   end

   logic       start;
   logic       start_evt;
   logic       busy;
   frame_req_t new_req;

   assign new_req = '{evt: start_evt, ql: ql, mac: src_mac};

   ssm_sched #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick_1s   (tick_1s),
      .ql        (ql),
      .busy      (busy),
      .start     (start),
      .start_evt (start_evt)
   );

   ssm_framer #(.VERSION(VERSION), .ORG_SUB(ORG_SUB)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .new_req  (new_req),
      .busy     (busy),
      .m_tready (m_tready),
      .m_tvalid (m_tvalid),
      .m_tdata  (m_tdata),
      .m_tlast  (m_tlast)
   );
endmodule

// File: rtl/ssm_frame_gen_chk.sv
module ssm_frame_gen_chk #(
   parameter int HOLDOFF_CYCLES = 12_500_000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       m_tvalid,
   input logic       m_tready,
   input logic [7:0] m_tdata,
   input logic       m_tlast
);
   localparam int GW = $clog2(HOLDOFF_CYCLES + 1) + 1;
   localparam logic [GW-1:0] GMAX = GW'(HOLDOFF_CYCLES);

   logic [6:0]    beat;
   logic          started;
   logic          new_frame;
   logic [GW-1:0] gap;

   assign new_frame = m_tvalid && (beat == 7'd0) && !started;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat    <= '0;
         started <= 1'b0;
         gap     <= GMAX;
      end else begin
         if (new_frame)              gap <= GW'(1);
         else if (gap < GMAX)        gap <= gap + 1'b1;
         if (m_tvalid && m_tready) begin
            if (m_tlast) begin
               beat    <= '0;
               started <= 1'b0;
            end else begin
               beat    <= beat + 1'b1;
               started <= 1'b1;
            end
         end else if (new_frame) begin
            started <= 1'b1;
         end
      end
   end

   assert_last_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tlast == (beat == 7'd63)));

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

   assert_dest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && beat == 7'd0) |-> (m_tdata == 8'h01));

   assert_flag_octet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && beat == 7'd20) |-> (m_tdata[7:4] == 4'h1 && m_tdata[2:0] == 3'b000));

   assert_tlv_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && beat == 7'd24) |-> (m_tdata == 8'h01));

   assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      new_frame |-> (gap >= GMAX));
endmodule

bind ssm_frame_gen ssm_frame_gen_chk #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tdata  (m_tdata),
   .m_tlast  (m_tlast)
);

// File: tb/ssm_frame_gen_tb.sv
module ssm_frame_gen_tb;
   localparam int HOLD = 100;

   typedef struct {
      bit        evt;
      bit [3:0]  ql;
      bit [47:0] mac;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        tick_1s = 1'b0;
   logic [3:0]  ql = 4'h0;
   logic [47:0] src_mac = 48'h0A1B2C3D4E5F;
   logic        m_tready = 1'b1;
   logic        m_tvalid;
   logic [7:0]  m_tdata;
   logic        m_tlast;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   frames_done = 0;
   int   sof_count = 0;
   int   sof_cyc = 0;
   int   chg_cyc = 0;
   bit   bp = 1'b0;
   bit   done = 1'b0;
   bit [15:0] lfsr = 16'hACE1;
   exp_t exp_q[$];

   ssm_frame_gen #(.HOLDOFF_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_1s(tick_1s), .ql(ql),
      .src_mac(src_mac), .m_tready(m_tready), .m_tvalid(m_tvalid),
      .m_tdata(m_tdata), .m_tlast(m_tlast)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_tready = bp ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // ---------------- scoreboard monitor ----------------
   bit [7:0] got [64];
   bit [7:0] expb [64];
   int  nb = 0;
   bit  in_frame = 0;
   int  last_sof = -1;
   bit  prev_stall = 0;
   bit [7:0] prev_data;

   task automatic build(input exp_t e);
      bit [31:0] c;
      for (int i = 0; i < 64; i++) expb[i] = 8'h00;
      expb[0] = 8'h01; expb[1] = 8'h80; expb[2] = 8'hC2; expb[5] = 8'h02;
      for (int i = 0; i < 6; i++) expb[6+i] = e.mac[47-8*i -: 8];
      expb[12] = 8'h88; expb[13] = 8'h09; expb[14] = 8'h0A;
      expb[16] = 8'h19; expb[17] = 8'hA7; expb[19] = 8'h01;
      expb[20] = {4'h1, e.evt, 3'b000};
      expb[24] = 8'h01; expb[26] = 8'h04; expb[27] = {4'h0, e.ql};
      c = 32'hFFFFFFFF;
      for (int i = 0; i < 60; i++)
         for (int b = 0; b < 8; b++) begin
            bit fb;
            fb = c[0] ^ expb[i][b];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
         end
      c = ~c;
      for (int k = 0; k < 4; k++) expb[60+k] = c[8*k +: 8];
   endtask

   task automatic cmp_range(input int lo, input int hi, input string req);
      int bad = -1;
      for (int i = lo; i <= hi; i++) if (bad < 0 && got[i] != expb[i]) bad = i;
      if (bad < 0) check(1'b1, req, "", 0, 0);
      else check(1'b0, req, $sformatf("beat %0d", bad), got[bad], expb[bad]);
   endtask

   task automatic finish_frame();
      exp_t e;
      check(nb == 64, "R2", "frame length", nb, 64);
      if (exp_q.size() == 0) begin
         check(1'b0, "R7", "unexpected frame flag", got[20][3], 0);
      end else begin
         e = exp_q.pop_front();
         build(e);
         if (e.evt) check(got[20][3] == 1'b1, "R8", "event flag", got[20][3], 1);
         else       check(got[20][3] == 1'b0, "R7", "info flag", got[20][3], 0);
         cmp_range(0, 19, "R3");
         cmp_range(20, 23, "R4");
         cmp_range(24, 59, "R5_R12");
         cmp_range(60, 63, "R6");
      end
      frames_done++;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(m_tvalid && m_tdata == prev_data, "R10", "stalled beat", m_tdata, prev_data);
         prev_stall = m_tvalid && !m_tready;
         prev_data  = m_tdata;
         if (m_tvalid && !in_frame) begin
            in_frame = 1;
            nb = 0;
            sof_count++;
            sof_cyc = cyc;
            if (last_sof >= 0)
               check(cyc - last_sof >= HOLD, "R9", "start spacing", cyc - last_sof, HOLD);
            last_sof = cyc;
         end
         if (m_tvalid && m_tready) begin
            if (nb < 64) got[nb] = m_tdata;
            nb++;
            if (m_tlast) begin
               in_frame = 0;
               finish_frame();
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_tick(input bit push);
      exp_t e;
      step(1);
      tick_1s = 1'b1;
      if (push) begin e.evt = 0; e.ql = ql; e.mac = src_mac; exp_q.push_back(e); end
      step(1);
      tick_1s = 1'b0;
   endtask

   task automatic set_ql(input bit [3:0] v, input bit push);
      exp_t e;
      step(1);
      ql = v;
      chg_cyc = cyc;
      if (push) begin e.evt = 1; e.ql = v; e.mac = src_mac; exp_q.push_back(e); end
   endtask

   task automatic wait_frames(input int k);
      while (frames_done < k) @(posedge clk);
      step(HOLD + 5);
   endtask

   initial begin
      exp_t e;
      step(4);
      check(m_tvalid === 1'b0, "R1", "tvalid in reset", m_tvalid, 0);
      rst_n = 1'b1;
      step(3);
      check(m_tvalid === 1'b0, "R1", "tvalid after reset", m_tvalid, 0);

      // disabled: stimuli ignored
      pulse_tick(0);
      set_ql(4'h2, 0);
      step(150);
      check(sof_count == 0, "R11", "frames while disabled", sof_count, 0);
      en = 1'b1;
      step(20);
      check(sof_count == 0, "R11", "frames after enable", sof_count, 0);

      // periodic info frame
      pulse_tick(1);
      wait_frames(1);

      // quality change -> event, latency
      set_ql(4'hB, 1);
      while (sof_count < 2) @(posedge clk);
      step(0);
      check(sof_cyc - chg_cyc <= 3, "R8", "event latency", sof_cyc - chg_cyc, 3);
      wait_frames(2);

      // event requested while an info frame is on the wire
      pulse_tick(1);
      while (sof_count < 3) @(posedge clk);
      step(5);
      set_ql(4'h4, 1);
      wait_frames(4);

      // simultaneous tick and change: event first
      step(1);
      ql = 4'hF; tick_1s = 1'b1;
      e.evt = 1; e.ql = 4'hF; e.mac = src_mac; exp_q.push_back(e);
      e.evt = 0; exp_q.push_back(e);
      step(1);
      tick_1s = 1'b0;
      wait_frames(6);

      // backpressure and new address
      src_mac = 48'hF0E1D2C3B4A5;
      bp = 1'b1;
      pulse_tick(1);
      set_ql(4'h1, 1);
      wait_frames(8);
      bp = 1'b0;

      // disable again: ignored
      en = 1'b0;
      pulse_tick(0);
      set_ql(4'h7, 0);
      step(HOLD * 2);
      check(sof_count == 8, "R11", "frames after disable", sof_count, 8);

      check(exp_q.size() == 0, "R7", "pending expected frames", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule